// File: doc/BRIEF.md
# Randomized-Frequency Gate PWM

This block drives the power switch of a flyback converter. The switching period changes pseudorandomly from one cycle to the next, so that switching energy spreads over a band of frequencies and does not pile up at one tone. At each cycle boundary the block latches a 16-bit random integer and an 8-bit duty command. The random integer gives the cycle length directly in clock ticks: a minimum period plus a scaled random term. The duty command is then scaled against that period to give the on-time in ticks.

A period counter, compared against the latched on-time, produces the main gate. A complementary gate fills the off interval of the same cycle, with a programmable dead time on both sides of it. At the last tick of each cycle the block emits a one-clock `cycle_start` pulse. The random source and the compensator that feed the block use this pulse to advance to their next values.

Top module: `rpwm_gate_top`

## Requirements
- R1: The period of a cycle in clock ticks is PMIN + ((rnd_in * A_SCALE) >> SHIFT). The value of rnd_in is taken at the clock edge on which `cycle_start` is high. The defaults are PMIN=40, A_SCALE=5 and SHIFT=14, which give periods from 40 to 59.
- R2: The on-time is (period * duty_in) >> 8 ticks. `gate_main` is high on cycle ticks 0 through on-time minus 1, and low for the rest of the cycle.
- R3: The tick counter counts 0, 1, … up to period minus 1, then returns to 0. Each cycle therefore lasts exactly `period` clocks.
- R4: `cycle_start` is high for exactly one clock, on the last tick of each cycle. rnd_in and duty_in are sampled only at that edge. Changes to them during a cycle have no effect on that cycle.
- R5: `gate_comp` is high on cycle ticks from on-time + DT_TICKS up to, but not including, period − DT_TICKS. DT_TICKS defaults to 3.
- R6: `gate_main` and `gate_comp` are never high together.
- R7: When the on-time works out to zero, both gates stay low for the whole cycle. This covers duty_in = 0, and also a small duty that rounds down to zero.
- R8: The on-time is clamped to at most period − DT_TICKS.
- R9: A synchronous reset drives both gates low. The first cycle after reset lasts PMIN ticks with both gates low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rnd_in | input | 16 | Random integer for the next cycle |
| duty_in | input | 8 | Duty command for the next cycle, in units of 1/256 |
| gate_main | output | 1 | Main switch gate |
| gate_comp | output | 1 | Complementary gate |
| cycle_start | output | 1 | One-clock pulse on the last tick of each cycle |

## Verification
The bench measures cycle length and gate tick counts across random values at both ends of the range. The boundary cases are:
- A duty large enough to need clamping. A design that skipped the clamp would hold `gate_main` into the dead band, or make the complementary count negative.
- A zero duty and a duty that rounds down to zero. A design that left `gate_comp` running here would produce a short complementary pulse with no main pulse.
- An input change in the middle of a cycle. This exposes a design that samples continuously instead of only at the boundary: the period or the on-time would shift inside the cycle.
- The first cycle after reset. This catches a design that reuses stale inputs instead of PMIN.

Dead-time placement is checked by recording the tick on which `gate_comp` first rises.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;
    parameter int CNT_W  = 16;
    parameter int RND_W  = 16;
    parameter int DUTY_W = 8;
    parameter int SCL_W  = 16;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] on;
    } rpwm_state_t;
endpackage

// File: rtl/rpwm_cycle_calc.sv
module rpwm_cycle_calc
    import rpwm_pkg::*;
#(
    parameter int PMIN     = 40,
    parameter int A_SCALE  = 5,
    parameter int SHIFT    = 14,
    parameter int DT_TICKS = 3
) (
    input  logic [RND_W-1:0]  rnd,
    input  logic [DUTY_W-1:0] duty,
    output logic [CNT_W-1:0]  per,
    output logic [CNT_W-1:0]  on
);
    localparam int PROD_W = RND_W + SCL_W;
    localparam int MUL_W  = CNT_W + DUTY_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] span;
    logic [MUL_W-1:0]  mul;
    logic [CNT_W-1:0]  on_raw;
    logic [CNT_W-1:0]  on_max;

    always_comb begin
        prod   = PROD_W'(rnd) * PROD_W'(SCL_W'(A_SCALE));
        span   = prod >> SHIFT;
        per    = CNT_W'(PMIN) + span[CNT_W-1:0];
        mul    = MUL_W'(per) * MUL_W'(duty);
        on_raw = mul[MUL_W-1:DUTY_W];
        on_max = per - CNT_W'(DT_TICKS);
        on     = (on_raw > on_max) ? on_max : on_raw;
    end
endmodule

// File: rtl/rpwm_gate_dec.sv
module rpwm_gate_dec
    import rpwm_pkg::*;
#(
    parameter int DT_TICKS = 3
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] on,
    output logic             hi,
    output logic             lo
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] lo_begin;
    logic [EXT_W-1:0] cnt_ahead;
    logic             live;

    always_comb begin
        live      = (on != '0);
        lo_begin  = EXT_W'(on) + EXT_W'(DT_TICKS);
        cnt_ahead = EXT_W'(cnt) + EXT_W'(DT_TICKS);
        hi        = live && (cnt < on);
        lo        = live && (EXT_W'(cnt) >= lo_begin) && (cnt_ahead < EXT_W'(per));
    end
endmodule

// File: rtl/rpwm_gate_top.sv
module rpwm_gate_top
    import rpwm_pkg::*;
#(
    parameter int PMIN     = 40,
    parameter int A_SCALE  = 5,
    parameter int SHIFT    = 14,
    parameter int DT_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RND_W-1:0]  rnd_in,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              gate_main,
    output logic              gate_comp,
    output logic              cycle_start
);
    localparam longint RND_MAX = (longint'(1) << RND_W) - 1;
    localparam int     PMAX    = PMIN + int'((RND_MAX * A_SCALE) >> SHIFT);

    rpwm_state_t st_q, st_d;
    logic [CNT_W-1:0] nxt_per;
    logic [CNT_W-1:0] nxt_on;
    logic             wrap;

    rpwm_cycle_calc #(
        .PMIN(PMIN), .A_SCALE(A_SCALE), .SHIFT(SHIFT), .DT_TICKS(DT_TICKS)
    ) u_calc (
        .rnd (rnd_in),
        .duty(duty_in),
        .per (nxt_per),
        .on  (nxt_on)
    );

    rpwm_gate_dec #(.DT_TICKS(DT_TICKS)) u_dec (
        .cnt(st_q.cnt),
        .per(st_q.per),
        .on (st_q.on),
        .hi (gate_main),
        .lo (gate_comp)
    );

    always_comb begin
        wrap = (st_q.cnt == st_q.per - CNT_W'(1));
        st_d = st_q;
        if (wrap) begin
            st_d.cnt = '0;
            st_d.per = nxt_per;
            st_d.on  = nxt_on;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= '0;
            st_q.per <= CNT_W'(PMIN);
            st_q.on  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cycle_start = wrap;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(gate_main && gate_comp)); // R6
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt < st_q.per); // R3
    AST_PER_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st_q.per >= CNT_W'(PMIN)) && (st_q.per <= CNT_W'(PMAX))); // R1
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> (st_q.cnt == '0)); // R3
    AST_HOLD_MID: assert property (@(posedge clk) disable iff (rst)
        !cycle_start |=> ($stable(st_q.per) && $stable(st_q.on))); // R4
    AST_ON_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (32'(st_q.on) + 32'(DT_TICKS)) <= 32'(st_q.per)); // R8
    AST_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
        (st_q.on == '0) |-> (!gate_main && !gate_comp)); // R7
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start); // R4
endmodule

// File: tb/tb_rpwm_gate_top.sv
module tb_rpwm_gate_top;
    localparam int NV = 7;
    localparam int DT = 3;
    localparam logic [15:0] V_RND [NV] = '{16'd0, 16'd65535, 16'd16384, 16'd40000, 16'd0, 16'd65535, 16'd16384};
    localparam logic [7:0]  V_DUTY[NV] = '{8'd128, 8'd64, 8'd255, 8'd0, 8'd1, 8'd200, 8'd200};
    localparam int          V_PER [NV] = '{40, 59, 45, 52, 40, 59, 45};
    localparam int          V_ON  [NV] = '{20, 14, 42, 0, 0, 46, 35};
    localparam int          V_LO  [NV] = '{14, 39, 0, 0, 0, 7, 4};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] rnd_in = '0;
    logic [7:0]  duty_in = '0;
    logic gate_main, gate_comp, cycle_start;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    int m_per, m_hi, m_lo, m_ovl, m_first_lo, m_hi0, m_starts;

    always #5 clk = ~clk;

    rpwm_gate_top dut (
        .clk(clk), .rst(rst), .rnd_in(rnd_in), .duty_in(duty_in),
        .gate_main(gate_main), .gate_comp(gate_comp), .cycle_start(cycle_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measures one cycle starting at the current negedge; ends on the negedge with cycle_start high.
    // A disturb tick >= 0 changes the inputs mid-cycle.
    task automatic measure(input int disturb, input logic [15:0] d_rnd, input logic [7:0] d_duty);
        m_per = 0; m_hi = 0; m_lo = 0; m_ovl = 0; m_first_lo = -1; m_hi0 = 0; m_starts = 0;
        for (int t = 0; t < 1000; t++) begin
            if (t == disturb) begin
                rnd_in  = d_rnd;
                duty_in = d_duty;
            end
            m_per++;
            if (t == 0) m_hi0 = int'(gate_main);
            if (gate_main) m_hi++;
            if (gate_comp) begin
                m_lo++;
                if (m_first_lo < 0) m_first_lo = t;
            end
            if (gate_main && gate_comp) m_ovl++;
            if (cycle_start) begin
                m_starts++;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic check_cycle(input int per, input int on, input int lo);
        chk(m_per == per, "R1/R3 period", m_per, per);
        chk(m_hi == on, "R2 on ticks", m_hi, on);
        chk(m_hi0 == (on > 0 ? 1 : 0), "R2 main high at tick 0", m_hi0, on > 0 ? 1 : 0);
        chk(m_lo == lo, "R5 comp ticks", m_lo, lo);
        if (lo > 0) chk(m_first_lo == on + DT, "R5 comp start after dead time", m_first_lo, on + DT);
        chk(m_ovl == 0, "R6 overlap", m_ovl, 0);
        chk(m_starts == 1, "R4 single start pulse", m_starts, 1);
    endtask

    initial begin
        #(10 * 100000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: gates low while in reset
        chk(!gate_main && !gate_comp, "R9 gates low in reset", int'(gate_main | gate_comp), 0);
        rnd_in  = 16'd65535;
        duty_in = 8'd128;
        rst = 1'b0;
        // R9: first cycle lasts PMIN with gates off
        measure(-1, '0, '0);
        check_cycle(40, 0, 0);

        // Table walk covering R1, R2, R5, R6, R7 (duty 0 and rounding to 0), R8 (clamp at index 2)
        for (int i = 0; i < NV; i++) begin
            rnd_in  = V_RND[i];
            duty_in = V_DUTY[i];
            @(negedge clk);
            chk(!cycle_start, "R4 start pulse one clock", int'(cycle_start), 0);
            measure(-1, '0, '0);
            check_cycle(V_PER[i], V_ON[i], V_LO[i]);
        end

        // R4: mid-cycle input change is ignored for the running cycle, taken at the next boundary
        rnd_in  = 16'd0;
        duty_in = 8'd128;
        @(negedge clk);
        measure(5, 16'd65535, 8'd0);
        check_cycle(40, 20, 14);
        @(negedge clk);
        measure(-1, '0, '0);
        check_cycle(59, 0, 0);

        // R8: full duty at the longest period is clamped to period - DT
        rnd_in  = 16'd65535;
        duty_in = 8'd255;
        @(negedge clk);
        measure(-1, '0, '0);
        check_cycle(59, 56, 0);

        // R9: reset in mid-run restarts at PMIN with gates off
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!gate_main && !gate_comp, "R9 gates low after reset", int'(gate_main | gate_comp), 0);
        rst = 1'b0;
        measure(-1, '0, '0);
        check_cycle(40, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule